// File: doc/BRIEF.md
# Chunk-Interleaved Tree Hash Compression Scheduler

This block sequences every compression call needed to hash a buffer made of a power-of-two number of fixed-size chunks. Each chunk holds sixteen 64-byte message blocks, and the blocks of one chunk are chained: the 8-word result of one block becomes the chaining input of the next. The scheduler does not finish one chunk before moving to the next. It takes block index 0 of every chunk in turn, then block index 1 of every chunk, and so on up to index 15. After each call it stores the result in a per-chunk slot of an internal chaining-value store. A later pass picks that value up again.

Once all sixteen passes are done, the per-chunk values form the leaves of a binary tree. The scheduler then merges neighbouring pairs level by level, writing each parent back in place, until one root is left. The compression function sits outside the block behind a valid/ready request port and a valid response port. Message blocks come from an external memory that answers a block address combinationally. A single start pulse runs the whole job. When the final parent result arrives, the block pulses done and holds the 256-bit root.

Top module: `hts_tree_sched`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `rsp_ready` and `done` are all 0.
- R2: Leaf requests are issued block-major and chunk-minor: (block 0, chunk 0..N-1), then (block 1, chunk 0..N-1), up to block 15. During each request `msg_addr` equals chunk*16 + block, `req_block` equals the memory word at that address, and `req_counter` equals the chunk index.
- R3: Every request has `req_len` = 64. The block-0 request of a chunk uses the initial constants as `req_cv`, with word 0 in bits 31:0. In word order 0..7 these constants are 6A09E667, BB67AE85, 3C6EF372, A54FF53A, 510E527F, 9B05688C, 1F83D9AB, 5BE0CD19 (hex). A leaf request sets flag bit 0 on block 0 and flag bit 1 on block 15, and sets no other flag bits.
- R4: For block b > 0 of chunk c, `req_cv` equals the response returned for block b-1 of chunk c.
- R5: After the leaves, level by level, slots (2k, 2k+1) merge into slot k, with k ascending. A parent request carries the left child in `req_block` bits 255:0 and the right child in bits 511:256. It also carries the initial constants as `req_cv`, a counter of 0 and flag bit 2. Only the single final parent call also sets flag bit 3.
- R6: At most one request is outstanding. `req_valid` stays low from acceptance until the response arrives. While `req_valid` is high and `req_ready` is low, every request field holds steady.
- R7: In the cycle after the final parent response is taken, `done` is high for exactly one cycle, `root` equals that response, and `busy` is low.
- R8: A start pulse while `busy` is high has no effect on the running sequence.
- R9: One job issues exactly 16*N + N - 1 requests and then none until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job when idle |
| busy | output | 1 | High while a job is running |
| done | output | 1 | One-cycle pulse when the root is ready |
| root | output | 256 | Final root chaining value |
| msg_addr | output | log2(N)+4 | Message block address, chunk*16 + block |
| msg_data | input | 512 | Message block at `msg_addr`, combinational |
| req_valid | output | 1 | Compression request valid |
| req_ready | input | 1 | Compression unit accepts request |
| req_cv | output | 256 | Input chaining value |
| req_block | output | 512 | Message or concatenated child values |
| req_counter | output | 64 | Chunk counter |
| req_len | output | 8 | Block length in bytes |
| req_flags | output | 8 | bit0 first block, bit1 last block, bit2 parent, bit3 root |
| rsp_valid | input | 1 | Compression result valid |
| rsp_ready | output | 1 | Scheduler waits for a result |
| rsp_cv | input | 256 | Compression result |

## Verification
A wrong chunk or block index shows at the ports as soon as the next request, through `msg_addr`, `req_counter` or the flags. A corrupted chaining slot, though, appears only when that chunk's next block is issued, which is N requests later, or in a parent request. The mock compressor therefore folds every request field into its result, so any earlier slip reaches the root and every later `req_cv`. A scheduling slip in the tree phase shows in the very next parent request through the child order in `req_block`.

// File: rtl/hts_pkg.sv
package hts_pkg;
    localparam int CV_WORDS  = 8;
    localparam int MSG_WORDS = 16;
    localparam int WORD_W    = 32;
    localparam int CV_W      = CV_WORDS * WORD_W;
    localparam int MSG_W     = MSG_WORDS * WORD_W;
    localparam int BLK_BYTES = 64;

    localparam int FLG_FIRST  = 0;
    localparam int FLG_LAST   = 1;
    localparam int FLG_PARENT = 2;
    localparam int FLG_ROOT   = 3;

    localparam logic [CV_W-1:0] INIT_CV = {
        32'h5BE0CD19, 32'h1F83D9AB, 32'h9B05688C, 32'h510E527F,
        32'hA54FF53A, 32'h3C6EF372, 32'hBB67AE85, 32'h6A09E667
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } sched_state_e;
endpackage

// File: rtl/hts_cv_store.sv
module hts_cv_store #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b
);
    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = slots[rd_addr_a];
    assign rd_data_b = slots[rd_addr_b];
endmodule

// File: rtl/hts_req_build.sv
module hts_req_build
    import hts_pkg::*;
#(
    parameter int N_CHUNKS = 4,
    parameter int BLOCKS   = 16,
    localparam int CW      = $clog2(N_CHUNKS),
    localparam int BW      = $clog2(BLOCKS),
    localparam int AW      = CW + BW
) (
    input  logic             parent,
    input  logic [BW-1:0]    blk,
    input  logic [CW-1:0]    idx,
    input  logic [CW-1:0]    pairs,
    input  logic [CV_W-1:0]  cv_a,
    input  logic [CV_W-1:0]  cv_b,
    input  logic [MSG_W-1:0] msg_data,
    output logic [CW-1:0]    rd_a,
    output logic [CW-1:0]    rd_b,
    output logic [AW-1:0]    msg_addr,
    output logic [CV_W-1:0]  req_cv,
    output logic [MSG_W-1:0] req_block,
    output logic [63:0]      req_counter,
    output logic [7:0]       req_flags
);
    logic [CW-1:0] left_slot;

    always_comb begin
        left_slot = CW'(idx << 1);
        rd_a      = parent ? left_slot : idx;
        rd_b      = left_slot | CW'(1);
        msg_addr  = {idx, blk};

        req_flags = '0;
        if (parent) begin
            req_cv                 = INIT_CV;
            req_block              = {cv_b, cv_a};
            req_counter            = '0;
            req_flags[FLG_PARENT]  = 1'b1;
            req_flags[FLG_ROOT]    = (pairs == CW'(1));
        end else begin
            req_cv                 = (blk == '0) ? INIT_CV : cv_a;
            req_block              = msg_data;
            req_counter            = 64'(idx);
            req_flags[FLG_FIRST]   = (blk == '0);
            req_flags[FLG_LAST]    = (blk == BW'(BLOCKS - 1));
        end
    end
endmodule

// File: rtl/hts_tree_sched.sv
module hts_tree_sched
    import hts_pkg::*;
#(
    parameter int N_CHUNKS = 4,
    parameter int BLOCKS   = 16,
    localparam int CW      = $clog2(N_CHUNKS),
    localparam int BW      = $clog2(BLOCKS),
    localparam int AW      = CW + BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [CV_W-1:0]  root,
    output logic [AW-1:0]    msg_addr,
    input  logic [MSG_W-1:0] msg_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [CV_W-1:0]  req_cv,
    output logic [MSG_W-1:0] req_block,
    output logic [63:0]      req_counter,
    output logic [7:0]       req_len,
    output logic [7:0]       req_flags,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [CV_W-1:0]  rsp_cv
);
    typedef struct packed {
        sched_state_e    st;
        logic            parent;
        logic [BW-1:0]   blk;
        logic [CW-1:0]   idx;
        logic [CW-1:0]   pairs;
        logic            done;
        logic [CV_W-1:0] root;
    } sched_t;

    sched_t s_d, s_q;

    logic [CW-1:0]   rd_a, rd_b;
    logic [CV_W-1:0] cv_a, cv_b;
    logic            take_rsp;

    assign take_rsp = (s_q.st == ST_WAIT) && rsp_valid;

    hts_cv_store #(.DEPTH(N_CHUNKS), .WIDTH(CV_W)) u_store (
        .clk       (clk),
        .wr_en     (take_rsp),
        .wr_addr   (s_q.idx),
        .wr_data   (rsp_cv),
        .rd_addr_a (rd_a),
        .rd_addr_b (rd_b),
        .rd_data_a (cv_a),
        .rd_data_b (cv_b)
    );

    hts_req_build #(.N_CHUNKS(N_CHUNKS), .BLOCKS(BLOCKS)) u_build (
        .parent      (s_q.parent),
        .blk         (s_q.blk),
        .idx         (s_q.idx),
        .pairs       (s_q.pairs),
        .cv_a        (cv_a),
        .cv_b        (cv_b),
        .msg_data    (msg_data),
        .rd_a        (rd_a),
        .rd_b        (rd_b),
        .msg_addr    (msg_addr),
        .req_cv      (req_cv),
        .req_block   (req_block),
        .req_counter (req_counter),
        .req_flags   (req_flags)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st     = ST_ISSUE;
                    s_d.parent = 1'b0;
                    s_d.blk    = '0;
                    s_d.idx    = '0;
                end
            end
            ST_ISSUE: begin
                if (req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    s_d.st = ST_ISSUE;
                    if (!s_q.parent) begin
                        if (s_q.idx == CW'(N_CHUNKS - 1)) begin
                            s_d.idx = '0;
                            if (s_q.blk == BW'(BLOCKS - 1)) begin
                                s_d.parent = 1'b1;
                                s_d.pairs  = CW'(N_CHUNKS / 2);
                            end else begin
                                s_d.blk = s_q.blk + BW'(1);
                            end
                        end else begin
                            s_d.idx = s_q.idx + CW'(1);
                        end
                    end else begin
                        if (s_q.idx == s_q.pairs - CW'(1)) begin
                            s_d.idx = '0;
                            if (s_q.pairs == CW'(1)) begin
                                s_d.st   = ST_IDLE;
                                s_d.done = 1'b1;
                                s_d.root = rsp_cv;
                            end else begin
                                s_d.pairs = s_q.pairs >> 1;
                            end
                        end else begin
                            s_d.idx = s_q.idx + CW'(1);
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, parent: 1'b0, blk: '0, idx: '0,
                     pairs: '0, done: 1'b0, root: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign req_valid = (s_q.st == ST_ISSUE);
    assign rsp_ready = (s_q.st == ST_WAIT);
    assign done      = s_q.done;
    assign root      = s_q.root;
    assign req_len   = 8'(BLK_BYTES);
endmodule

// File: rtl/hts_tree_sched_chk.sv
module hts_tree_sched_chk
    import hts_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CV_W-1:0]  req_cv,
    input logic [MSG_W-1:0] req_block,
    input logic [63:0]      req_counter,
    input logic [7:0]       req_len,
    input logic [7:0]       req_flags,
    input logic             rsp_valid,
    input logic             rsp_ready
);
    logic [1:0] outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding + 2'(req_valid && req_ready)
                                       - 2'(rsp_valid && rsp_ready);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_cv) && $stable(req_block)
                                    && $stable(req_counter) && $stable(req_flags)); // R6
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> outstanding == 2'd0); // R6
    AST_BLOCK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len == 8'd64); // R3
    AST_FIRST_BLOCK_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_flags[FLG_FIRST] |-> req_cv == INIT_CV && !req_flags[FLG_PARENT]); // R3
    AST_PARENT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_flags[FLG_PARENT] |-> req_cv == INIT_CV && req_counter == 64'd0
                                               && !req_flags[FLG_FIRST] && !req_flags[FLG_LAST]); // R5
    AST_ROOT_IS_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_flags[FLG_ROOT] |-> req_flags[FLG_PARENT]); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !req_valid); // R7
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !rsp_valid |=> busy); // R8
endmodule

bind hts_tree_sched hts_tree_sched_chk u_chk (.*);

// File: tb/hts_tree_sched_test.sv
module hts_tree_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int BLKS = 16;
    localparam int AW   = $clog2(N) + 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           busy, done;
    logic [255:0]   root;
    logic [AW-1:0]  msg_addr;
    logic [511:0]   msg_data;
    logic           req_valid;
    logic           req_ready = 1'b0;
    logic [255:0]   req_cv;
    logic [511:0]   req_block;
    logic [63:0]    req_counter;
    logic [7:0]     req_len, req_flags;
    logic           rsp_valid = 1'b0;
    logic           rsp_ready;
    logic [255:0]   rsp_cv = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int seed     = 1;
    int req_num  = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hts_tree_sched #(.N_CHUNKS(N), .BLOCKS(BLKS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .root(root),
        .msg_addr(msg_addr), .msg_data(msg_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_cv(req_cv), .req_block(req_block), .req_counter(req_counter), .req_len(req_len),
        .req_flags(req_flags), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cv(rsp_cv)
    );

    localparam logic [255:0] IV = {32'h5BE0CD19, 32'h1F83D9AB, 32'h9B05688C, 32'h510E527F,
                                   32'hA54FF53A, 32'h3C6EF372, 32'hBB67AE85, 32'h6A09E667};

    function automatic logic [511:0] msg_fn(int s, int a);
        logic [511:0] m;
        for (int w = 0; w < 16; w++) begin
            m[w*32 +: 32] = 32'h9E3779B9 * 32'(a * 16 + w + 1) ^ (32'(s) * 32'h01000193);
        end
        return m;
    endfunction

    function automatic logic [255:0] mix(logic [255:0] cv, logic [511:0] b,
                                         logic [63:0] ctr, logic [7:0] fl);
        logic [255:0] o;
        logic [31:0]  hi;
        for (int w = 0; w < 8; w++) begin
            hi = b[(w+8)*32 +: 32];
            o[w*32 +: 32] = (cv[w*32 +: 32] ^ b[w*32 +: 32]) + {hi[26:0], hi[31:27]}
                            + ctr[31:0] + 32'(fl) * 32'(w + 3);
        end
        return o;
    endfunction

    assign msg_data = msg_fn(seed, int'(msg_addr));

    task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(string tag, logic [255:0] ecv, logic [511:0] eblk,
                          logic [63:0] ectr, logic [7:0] efl, int eaddr, bit poke_start);
        logic [255:0] c_cv;
        logic [511:0] c_blk;
        logic [63:0]  c_ctr;
        logic [7:0]   c_fl;
        while (!req_valid) @(negedge clk);
        check(req_cv == ecv, {tag, " cv"}, 512'(req_cv), 512'(ecv));
        check(req_block == eblk, {tag, " block"}, req_block, eblk);
        check(req_counter == ectr && req_flags == efl && req_len == 8'd64, {tag, " ctr/flags/len"},
              512'({req_counter, req_flags, req_len}), 512'({ectr, efl, 8'd64}));
        if (!efl[2]) check(int'(msg_addr) == eaddr, "R2 msg_addr", 512'(msg_addr), 512'(eaddr));
        c_cv = req_cv; c_blk = req_block; c_ctr = req_counter; c_fl = req_flags;
        for (int h = 0; h < req_num % 3; h++) @(negedge clk);
        check(req_valid && req_cv == c_cv && req_block == c_blk && req_flags == c_fl,
              "R6 hold while not ready", 512'(req_cv), 512'(c_cv));
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check(!req_valid && rsp_ready, "R6 no second request", 512'(req_valid), 512'(0));
        for (int d = 0; d < req_num % 4; d++) begin
            if (poke_start && d == 0) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(!req_valid, "R6 idle while waiting", 512'(req_valid), 512'(0));
        end
        rsp_cv    = mix(c_cv, c_blk, c_ctr, c_fl);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        req_num++;
    endtask

    task automatic run_job(int s, int poke_at);
        logic [255:0] model [N];
        logic [255:0] ecv;
        logic [511:0] eb;
        logic [7:0]   ef;
        int issued = 0;
        seed = s;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 R3 R4: leaf sweeps, block-major
        for (int b = 0; b < BLKS; b++) begin
            for (int c = 0; c < N; c++) begin
                ecv = (b == 0) ? IV : model[c];
                eb  = msg_fn(s, c * 16 + b);
                ef  = {6'd0, b == BLKS - 1, b == 0};
                do_req((b == 0) ? "R3 leaf" : "R4 leaf", ecv, eb, 64'(c), ef,
                       c * 16 + b, issued == poke_at);
                if (issued == poke_at) begin
                    // R8: start pulsed mid-job; next request must continue the sequence
                    while (!req_valid) @(negedge clk);
                    check(int'(msg_addr) == ((c + 1) % N) * 16 + b + (c + 1) / N,
                          "R8 start ignored while busy", 512'(msg_addr), 512'(0));
                end
                model[c] = mix(ecv, eb, 64'(c), ef);
                issued++;
            end
        end
        // R5: pairwise reduction in place
        for (int p = N / 2; p >= 1; p = p / 2) begin
            for (int k = 0; k < p; k++) begin
                eb = {model[2*k+1], model[2*k]};
                ef = (p == 1) ? 8'h0C : 8'h04;
                do_req("R5 parent", IV, eb, 64'd0, ef, 0, 1'b0);
                model[k] = mix(IV, eb, 64'd0, ef);
                issued++;
            end
        end
        check(done && !busy && root == model[0], "R7 done and root",
              512'({done, busy, root}), 512'({1'b1, 1'b0, model[0]}));
        @(negedge clk);
        check(!done, "R7 done single cycle", 512'(done), 512'(0));
        check(issued == 16 * N + N - 1, "R9 request total", 512'(issued), 512'(16 * N + N - 1));
        for (int q = 0; q < 5; q++) begin
            @(negedge clk);
            check(!req_valid && !busy, "R9 quiet after done", 512'(req_valid), 512'(0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !req_valid && !rsp_ready && !done, "R1 reset state",
              512'({busy, req_valid, rsp_ready, done}), 512'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R1 idle after reset",
              512'({busy, req_valid, done}), 512'(0));
        run_job(1, 21);
        run_job(7, -1);
        run_job(42, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule